// File: doc/BRIEF.md
# Banked Level Interrupt Mask Controller

This block gathers up to 256 level-sensitive interrupt lines, organised as 32-bit words, and presents them to several processors. Each processor owns a private bank of mask registers and one interrupt output. A processor's output is high while any source is both active and unmasked in that processor's bank. Software routes a source to a processor by clearing the source's mask bit only in that processor's bank.

Registers are reached through a single 32-bit read/write port with one cycle of latency. Each bank occupies a 128-byte window. Inside a window the registers are grouped by type, and the stride between groups equals the word count. Mask changes use separate write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed.

A small access state machine in the port sequences the responses. ACC_IDLE means no response is due. ACC_READ means a read response is due this cycle. ACC_WRITE means a write acknowledge is due this cycle. Every state makes the same transitions. A read request moves it to ACC_READ, a write request moves it to ACC_WRITE, and a cycle without a request returns it to ACC_IDLE.

Top module: `irq_mask_hub`

## Requirements
- R1: After reset every mask bit in every bank is 1, every `irq_out` bit is 0 and `rsp_valid` is 0.
- R2: Byte address = bank·128 + 4·(k·N + w), where N = NUM_WORDS and w is the word index. The group index k is 0 for status, 1 for mask readback, 2 for mask set and 3 for mask clear. Source n maps to word n/32, bit n%32. Address bits 1:0 are ignored.
- R3: A status read returns `irq_src` for that word as sampled at the request edge, with no latching. Writes to status change nothing.
- R4: A write to mask set ORs the one bits of the data into the addressed mask word. Zero bits leave the mask unchanged.
- R5: A write to mask clear clears the addressed mask bits that are one in the data. Zero bits leave the mask unchanged.
- R6: `irq_out[c]` is registered. After each clock edge it equals the OR over all words of `irq_src & ~mask` for bank c at that edge, so a mask write is visible on the output one cycle after the write edge.
- R7: A write to one bank never changes the masks or the output of another bank.
- R8: Mask readback returns the current mask word. Mask set and mask clear read as 0.
- R9: Addresses that hit nothing read 0, and writes to them change no mask. These are a bank offset of 16·N or more, a bank index of NUM_CPUS or more, and any nonzero bit above the bank index.
- R10: `rsp_valid` is high exactly in the cycle after each accepted request and low otherwise. A write response carries data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_src | input | 32·NUM_WORDS | Level interrupt sources |
| irq_out | output | NUM_CPUS | Per-processor interrupt output |

## Verification
The bench runs with three words and three banks, so neither count is a power of two. Mask words are driven with set and clear patterns that include all-zero data. This separates a true OR or AND-NOT update from a plain overwrite and from a wrong word index. Source patterns place one active bit under a masked position and then under an unmasked one. This shows whether the mask gates individual bits or whole words, and whether the output appears exactly one cycle after a mask write. Out-of-range writes aimed at a fourth bank, at the offset past the last group and at a set upper address bit each show whether the design aliases such addresses onto a real bank.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
    localparam int WORD_BITS = 32;
    localparam int BANK_LG   = 7;   // 128-byte window per bank (16 bytes x 8 words)

    typedef enum logic [2:0] {
        RK_STATUS = 3'd0,
        RK_MSTAT  = 3'd1,
        RK_MSET   = 3'd2,
        RK_MCLR   = 3'd3,
        RK_NONE   = 3'd4
    } reg_kind_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_e;
endpackage

// File: rtl/irqhub_decode.sv
module irqhub_decode
    import irqhub_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 12,
    parameter int WORD_W    = 1,
    parameter int BANK_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BANK_W-1:0] bank,
    output reg_kind_e         kind,
    output logic [WORD_W-1:0] word
);
    localparam int OFS_N = BANK_LG - 2;

    logic [OFS_N-1:0] off;
    logic             upper_zero;
    logic             unused_lo;

    assign off        = addr[BANK_LG-1:2];
    assign bank       = addr[BANK_LG +: BANK_W];
    assign upper_zero = ((addr >> (BANK_LG + BANK_W)) == '0);
    assign unused_lo  = ^addr[1:0];

    always_comb begin
        kind = RK_NONE;
        word = '0;
        for (int k = 0; k < 4; k++) begin
            if (int'(off) >= k * NUM_WORDS && int'(off) < (k + 1) * NUM_WORDS) begin
                kind = reg_kind_e'(3'(k));
                word = WORD_W'(int'(off) - k * NUM_WORDS);
            end
        end
    end

    assign hit = upper_zero && (int'(bank) < NUM_CPUS) && (kind != RK_NONE);
endmodule

// File: rtl/irqhub_bank.sv
module irqhub_bank
    import irqhub_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  set_en,
    input  logic                                  clr_en,
    input  logic [WORD_W-1:0]                     word_sel,
    input  logic [WORD_BITS-1:0]                  wdata,
    input  logic [NUM_WORDS*WORD_BITS-1:0]        src,
    output logic [NUM_WORDS-1:0][WORD_BITS-1:0]   mask_o,
    output logic                                  irq_o
);
    localparam int SRC_N = NUM_WORDS * WORD_BITS;

    logic [NUM_WORDS-1:0][WORD_BITS-1:0] mask_q;
    logic [SRC_N-1:0]                    mask_flat;
    logic                                irq_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[w] <= '1;
            end else if (set_en && word_sel == WORD_W'(w)) begin
                mask_q[w] <= mask_q[w] | wdata;
            end else if (clr_en && word_sel == WORD_W'(w)) begin
                mask_q[w] <= mask_q[w] & ~wdata;
            end
        end
    end

    assign mask_flat = mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(src & ~mask_flat);
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;

    // Checker view: write data placed at the addressed word position.
    logic [SRC_N-1:0] wvec;
    assign wvec = SRC_N'(wdata) << (int'(word_sel) * WORD_BITS);

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_flat & $past(wvec)) == $past(wvec)));

    assert_mask_set_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_flat & ~$past(wvec)) == ($past(mask_flat) & ~$past(wvec))));

    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((mask_flat & $past(wvec)) == '0));

    assert_mask_clr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((mask_flat & ~$past(wvec)) == ($past(mask_flat) & ~$past(wvec))));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en) |=> $stable(mask_flat));

    assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(src) & ~$past(mask_flat))));
endmodule

// File: rtl/irqhub_port.sv
module irqhub_port
    import irqhub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [WORD_BITS-1:0] rd_value,
    output logic                 rsp_valid,
    output logic [WORD_BITS-1:0] rsp_rdata
);
    acc_state_e             state_q, state_d;
    logic [WORD_BITS-1:0]   rdata_q;

    // next-state logic
    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_READ, ACC_WRITE: begin
                if (req_valid) state_d = req_write ? ACC_WRITE : ACC_READ;
                else           state_d = ACC_IDLE;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // state register and captured read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (req_valid && !req_write) ? rd_value : '0;
        end
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ACC_IDLE:  begin rsp_valid = 1'b0; rsp_rdata = '0;      end
            ACC_READ:  begin rsp_valid = 1'b1; rsp_rdata = rdata_q; end
            ACC_WRITE: begin rsp_valid = 1'b1; rsp_rdata = '0;      end
            default:   begin rsp_valid = 1'b0; rsp_rdata = '0;      end
        endcase
    end

    assert_rsp_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_write_rsp_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: rtl/irq_mask_hub.sv
module irq_mask_hub
    import irqhub_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [WORD_BITS-1:0]           req_wdata,
    output logic                           rsp_valid,
    output logic [WORD_BITS-1:0]           rsp_rdata,
    input  logic [NUM_WORDS*WORD_BITS-1:0] irq_src,
    output logic [NUM_CPUS-1:0]            irq_out
);
    localparam int WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int BANK_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

    logic              dec_hit;
    logic [BANK_W-1:0] dec_bank;
    reg_kind_e         dec_kind;
    logic [WORD_W-1:0] dec_word;

    irqhub_decode #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_CPUS  (NUM_CPUS),
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .BANK_W    (BANK_W)
    ) u_dec (
        .addr (req_addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .kind (dec_kind),
        .word (dec_word)
    );

    logic [NUM_WORDS-1:0][WORD_BITS-1:0]               src_w;
    logic [NUM_CPUS-1:0][NUM_WORDS-1:0][WORD_BITS-1:0] mask_all;
    logic [NUM_CPUS-1:0]                               set_en, clr_en;
    logic                                              wr_hit;

    assign src_w  = irq_src;
    assign wr_hit = req_valid && req_write && dec_hit;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        assign set_en[c] = wr_hit && (dec_kind == RK_MSET) && (int'(dec_bank) == c);
        assign clr_en[c] = wr_hit && (dec_kind == RK_MCLR) && (int'(dec_bank) == c);

        irqhub_bank #(
            .NUM_WORDS (NUM_WORDS),
            .WORD_W    (WORD_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (set_en[c]),
            .clr_en   (clr_en[c]),
            .word_sel (dec_word),
            .wdata    (req_wdata),
            .src      (irq_src),
            .mask_o   (mask_all[c]),
            .irq_o    (irq_out[c])
        );
    end

    logic [WORD_BITS-1:0] rd_value;

    always_comb begin
        rd_value = '0;
        if (dec_hit) begin
            unique case (dec_kind)
                RK_STATUS: rd_value = src_w[dec_word];
                RK_MSTAT:  rd_value = mask_all[dec_bank][dec_word];
                default:   rd_value = '0;
            endcase
        end
    end

    irqhub_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rd_value  (rd_value),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_en | clr_en));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/sim_irq_mask_hub.sv
module sim_irq_mask_hub;
    localparam int N  = 3;
    localparam int C  = 3;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [N*32-1:0] irq_src = '0;
    logic [C-1:0]  irq_out;

    always #5 clk = ~clk;

    irq_mask_hub #(.NUM_WORDS(N), .NUM_CPUS(C), .ADDR_W(AW)) u0 (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .rsp_valid, .rsp_rdata, .irq_src, .irq_out
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] mdl [C][N];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ra(int b, int k, int w);
        return AW'(b * 128 + 4 * (k * N + w));
    endfunction

    // monitor: pop expected responses
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    task automatic bus(logic wr, logic [AW-1:0] a, logic [31:0] d, logic [31:0] e, string t);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] e, string t);
        bus(1'b0, a, 32'h0, e, t);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d, string t);
        bus(1'b1, a, d, 32'h0, t);
    endtask

    task automatic wr_set(int b, int w, logic [31:0] d, string t);
        mdl[b][w] = mdl[b][w] | d;
        wr(ra(b, 2, w), d, t);
    endtask

    task automatic wr_clr(int b, int w, logic [31:0] d, string t);
        mdl[b][w] = mdl[b][w] & ~d;
        wr(ra(b, 3, w), d, t);
    endtask

    task automatic chk_mask(int b, int w, string t);
        rd(ra(b, 1, w), mdl[b][w], t);
    endtask

    function automatic logic [C-1:0] exp_irq();
        logic [C-1:0] r;
        for (int c = 0; c < C; c++) begin
            logic [N*32-1:0] m;
            for (int w = 0; w < N; w++) m[w*32 +: 32] = mdl[c][w];
            r[c] = |(irq_src & ~m);
        end
        return r;
    endfunction

    task automatic chk_irq(string t);
        repeat (2) @(negedge clk);
        check(irq_out === exp_irq(), t, 32'(irq_out), 32'(exp_irq()));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < C; c++)
            for (int w = 0; w < N; w++) mdl[c][w] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        check(irq_out === '0, "R1 irq_out in reset", 32'(irq_out), 32'h0);
        rst_n = 1'b1;

        // R1: every mask bit set after reset
        for (int c = 0; c < C; c++)
            for (int w = 0; w < N; w++) chk_mask(c, w, "R1 reset mask");
        irq_src = {32'hA5A5_0F0F, 32'h8000_0001, 32'h1234_5678};
        chk_irq("R1 all masked, no irq");

        // R3/R2: status reads of live levels per word
        rd(ra(0, 0, 0), 32'h1234_5678, "R3 status w0");
        rd(ra(1, 0, 1), 32'h8000_0001, "R3 status w1 bank1");
        rd(ra(2, 0, 2), 32'hA5A5_0F0F, "R2 status w2 bank2");
        wr(ra(0, 0, 1), 32'hFFFF_FFFF, "R3 status write resp");
        rd(ra(0, 0, 1), 32'h8000_0001, "R3 status unchanged by write");
        chk_mask(0, 1, "R3 status write leaves mask");
        irq_src = {32'h0, 32'h0000_0F00, 32'h0};
        rd(ra(0, 0, 1), 32'h0000_0F00, "R3 status follows input");

        // R4/R5: set and clear semantics
        wr_clr(0, 1, 32'h0000_00F0, "R5 clr resp");
        chk_mask(0, 1, "R5 clr 0xF0");
        wr_set(0, 1, 32'h0000_0010, "R4 set resp");
        chk_mask(0, 1, "R4 set 0x10");
        wr_clr(0, 1, 32'h0, "R5 clr zero resp");
        chk_mask(0, 1, "R5 clr zero no change");
        wr_set(0, 1, 32'h0, "R4 set zero resp");
        chk_mask(0, 1, "R4 set zero no change");
        wr_clr(2, 2, 32'h8000_0000, "R2 clr bank2 w2 resp");
        chk_mask(2, 2, "R2 bank2 w2 mask");

        // R6: output gating and timing
        irq_src = '0;
        irq_src[36] = 1'b1;   // word1 bit4, masked in bank0
        chk_irq("R6 masked source no irq");
        irq_src = '0;
        irq_src[37] = 1'b1;   // word1 bit5, unmasked in bank0
        chk_irq("R6 unmasked source irq");
        check(irq_out[0] === 1'b1, "R6 bank0 asserted", 32'(irq_out), 32'h1);
        wr_set(0, 1, 32'h0000_0020, "R6 mask resp");
        check(irq_out[0] === 1'b1, "R6 output one cycle after write", 32'(irq_out[0]), 32'h1);
        @(negedge clk);
        check(irq_out[0] === 1'b0, "R6 masked next cycle", 32'(irq_out[0]), 32'h0);
        irq_src = '0;
        irq_src[95] = 1'b1;   // word2 bit31
        chk_irq("R6 word2 in bank2");
        check(irq_out === 3'b100, "R7 only bank2 sees word2 bit31", 32'(irq_out), 32'h4);

        // R7: bank independence
        chk_mask(1, 1, "R7 bank1 untouched");
        chk_mask(1, 2, "R7 bank1 w2 untouched");
        wr_clr(1, 0, 32'h0000_0001, "R7 clr bank1 resp");
        irq_src[0] = 1'b1;
        chk_irq("R7 bank1 alone takes bit0");
        chk_mask(0, 0, "R7 bank0 w0 untouched");
        chk_mask(2, 0, "R7 bank2 w0 untouched");

        // R8: readback of set/clear registers
        rd(ra(0, 2, 1), 32'h0, "R8 set reads zero");
        rd(ra(1, 3, 0), 32'h0, "R8 clr reads zero");

        // R9: out-of-range
        rd(AW'(4 * 4 * N), 32'h0, "R9 offset past groups reads zero");
        wr(AW'(4 * 4 * N), 32'hFFFF_FFFF, "R9 write past groups resp");
        wr(AW'(3 * 128 + 4 * (3 * N + 0)), 32'hFFFF_FFFF, "R9 bank3 clr resp");
        rd(AW'(3 * 128 + 4 * (0 * N + 0)), 32'h0, "R9 bank3 status reads zero");
        wr(AW'(12'h800) | ra(0, 3, 0), 32'hFFFF_FFFF, "R9 upper bit clr resp");
        rd(AW'(12'h800) | ra(0, 0, 0), 32'h0, "R9 upper bit status reads zero");
        for (int c = 0; c < C; c++)
            for (int w = 0; w < N; w++) chk_mask(c, w, "R9 masks unchanged");
        chk_irq("R9 outputs unchanged");

        // R10: response timing
        repeat (2) @(negedge clk);
        check(rsp_valid === 1'b0, "R10 idle no response", 32'(rsp_valid), 32'h0);
        check(exp_q.size() == 0, "R10 all responses seen", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule